// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block drives one conversion on a small serial successive-approximation converter. The converter has a single conversion-start pin, a serial clock input and a serial data output. A host asserts `req_i` together with `sel_alt_i`. `sel_alt_i = 0` asks for the primary choice (first channel, or unipolar straight-binary coding). `sel_alt_i = 1` asks for the alternate choice (second channel, or bipolar two's-complement coding). The sequencer encodes that choice as a pulse pattern on `start_o`, keeps the track phase open for a set number of cycles, and waits out the conversion. It then issues exactly twelve serial clock periods and shifts the reply in MSB first.

The converter falls back to the alternate choice by itself whenever a readout stops early. For that reason, every accepted request always runs to a full twelve-bit readout. At the end the sequencer presents the 12-bit word and a 16-bit copy of it. In the copy, the upper bits repeat the sign bit for the alternate choice and are zero for the primary choice. The sequencer also pulses `done_o` for one cycle. All phase lengths are parameters counted in system-clock cycles. The defaults assume a 125 MHz system clock.

The controller is a single state machine, and `busy_o` is high whenever it is out of Idle. Its states and transitions are:

| State | Pins | Next state |
|---|---|---|
| Idle | start low, SCLK low | A request with `sel_alt_i=1` goes to Select-High; a request with `sel_alt_i=0` goes to Track. |
| Select-High | start high | After `SEL_CYC` cycles, goes to Select-Low. |
| Select-Low | start low | After `SEL_CYC` cycles, goes to Track. |
| Track | start high | After `ACQ_CYC` cycles, goes to Convert. |
| Convert | start low | After `CONV_CYC` cycles, goes to Clock-Low. |
| Clock-Low | SCLK low | After `HALF_CYC` cycles, samples the data input and goes to Clock-High. |
| Clock-High | SCLK high | After `HALF_CYC` cycles, returns to Clock-Low while fewer than 12 bits are in. Once the twelfth bit is in, it latches the result and goes to Done. |
| Done | — | Asserts `done_o` for one cycle, then goes to Idle. |

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `start_o`, `sclk_o`, `done_o`, `busy_o` and `alt_o` are 0, and `result_o` and `ext_o` are all zeros.
- R2: A request with `sel_alt_i=0` produces one high pulse on `start_o` lasting exactly `ACQ_CYC` cycles, with no earlier pulse.
- R3: A request with `sel_alt_i=1` first drives `start_o` high for `SEL_CYC` cycles and low for `SEL_CYC` cycles. It then drives `start_o` high for `ACQ_CYC` cycles.
- R4: The first rising edge of `sclk_o` comes at least `CONV_CYC` cycles after the falling edge of `start_o` that ends the track phase.
- R5: Each conversion has exactly 12 SCLK periods, with every high and low phase exactly `HALF_CYC` cycles long. `start_o` is low whenever `sclk_o` is high, so the converter never sees an unfinished readout.
- R6: `sdata_i` is sampled when `sclk_o` rises, and the first sample lands in `result_o[11]` (MSB first).
- R7: `done_o` is high for exactly one cycle per conversion. In that same cycle, `result_o`, `ext_o` and `alt_o` (equal to the request's `sel_alt_i`) take their new values, and they hold until the next `done_o`.
- R8: `ext_o[11:0]` equals `result_o`. `ext_o[15:12]` repeats `result_o[11]` when `alt_o=1` and is zero when `alt_o=0`.
- R9: A request while `busy_o` is high is ignored: it starts no further conversion and does not change the selection in use.
- R10: `busy_o` rises in the cycle after an accepted request and falls in the cycle after `done_o`. While `busy_o` is low, both `start_o` and `sclk_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Conversion request, sampled in Idle |
| sel_alt_i | input | 1 | 0 = primary choice, 1 = alternate choice |
| sdata_i | input | 1 | Serial data from the converter |
| start_o | output | 1 | Conversion-start pin |
| sclk_o | output | 1 | Serial clock to the converter |
| result_o | output | 12 | Last assembled result |
| ext_o | output | 16 | Extended copy of the result |
| alt_o | output | 1 | Choice that produced the held result |
| done_o | output | 1 | One-cycle completion strobe |
| busy_o | output | 1 | Conversion in progress |

## Verification
The bench builds the block with `SEL_CYC=2`, `ACQ_CYC=5`, `CONV_CYC=7` and `HALF_CYC=2`. With these values a conversion lasts about sixty cycles, so the run covers several dozen conversions. These include all-ones, all-zeros and both sign-boundary words in each mode.

Because the select pulse (2 cycles) is much shorter than the track pulse (5 cycles), the bench's converter model can tell the two apart by width. That lets it decode the requested choice from the start pin alone. The model shifts the word out on SCLK falling edges. It also flags any conversion that begins after an incomplete readout, which would force the alternate choice.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEL_HI,
        S_SEL_LO,
        S_TRACK,
        S_CONV,
        S_SCK_LO,
        S_SCK_HI,
        S_DONE
    } seq_state_e;

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_i,
    input  logic [TW-1:0] ld_val_i,
    output logic          zero_o
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld_i) begin
            cnt_q <= ld_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift #(
    parameter int NBITS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             smp_i,
    input  logic             bit_i,
    output logic [NBITS-1:0] data_o,
    output logic             full_o
);

    localparam int CW = $clog2(NBITS + 1);

    logic [NBITS-1:0] sh_q;
    logic [CW-1:0]    cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (clr_i) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (smp_i) begin
            sh_q  <= {sh_q[NBITS-2:0], bit_i};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign data_o = sh_q;
    assign full_o = (cnt_q == CW'(NBITS));

endmodule

// File: rtl/adc_seq_fmt.sv
module adc_seq_fmt #(
    parameter int NBITS = 12,
    parameter int EXT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic             alt_i,
    input  logic [NBITS-1:0] data_i,
    output logic [NBITS-1:0] result_o,
    output logic [EXT_W-1:0] ext_o,
    output logic             alt_o
);

    logic [EXT_W-1:0] ext_d;

    assign ext_d[NBITS-1:0] = data_i;

    for (genvar g = NBITS; g < EXT_W; g++) begin : g_ext
        assign ext_d[g] = alt_i & data_i[NBITS-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o <= '0;
            ext_o    <= '0;
            alt_o    <= 1'b0;
        end else if (cap_i) begin
            result_o <= data_i;
            ext_o    <= ext_d;
            alt_o    <= alt_i;
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NBITS    = 12,
    parameter int EXT_W    = 16,
    parameter int SEL_CYC  = 4,
    parameter int ACQ_CYC  = 175,
    parameter int CONV_CYC = 463,
    parameter int HALF_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             sel_alt_i,
    input  logic             sdata_i,
    output logic             start_o,
    output logic             sclk_o,
    output logic [NBITS-1:0] result_o,
    output logic [EXT_W-1:0] ext_o,
    output logic             alt_o,
    output logic             done_o,
    output logic             busy_o
);

    localparam int M_A     = (SEL_CYC > ACQ_CYC) ? SEL_CYC : ACQ_CYC;
    localparam int M_B     = (CONV_CYC > HALF_CYC) ? CONV_CYC : HALF_CYC;
    localparam int MAX_CYC = (M_A > M_B) ? M_A : M_B;
    localparam int TW      = $clog2(MAX_CYC + 1);

    seq_state_e       state_q, state_d;
    logic             sel_q;
    logic             tmr_ld, tmr_zero;
    logic [TW-1:0]    tmr_val;
    logic             smp, clr, cap, full;
    logic [NBITS-1:0] shift_data;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            sel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && req_i) begin
                sel_q <= sel_alt_i;
            end
        end
    end

    // next state and phase timer loads
    always_comb begin
        state_d = state_q;
        tmr_ld  = 1'b0;
        tmr_val = '0;
        smp     = 1'b0;
        clr     = 1'b0;
        cap     = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req_i) begin
                    clr    = 1'b1;
                    tmr_ld = 1'b1;
                    if (sel_alt_i) begin
                        state_d = S_SEL_HI;
                        tmr_val = TW'(SEL_CYC - 1);
                    end else begin
                        state_d = S_TRACK;
                        tmr_val = TW'(ACQ_CYC - 1);
                    end
                end
            end
            S_SEL_HI: begin
                if (tmr_zero) begin
                    state_d = S_SEL_LO;
                    tmr_ld  = 1'b1;
                    tmr_val = TW'(SEL_CYC - 1);
                end
            end
            S_SEL_LO: begin
                if (tmr_zero) begin
                    state_d = S_TRACK;
                    tmr_ld  = 1'b1;
                    tmr_val = TW'(ACQ_CYC - 1);
                end
            end
            S_TRACK: begin
                if (tmr_zero) begin
                    state_d = S_CONV;
                    tmr_ld  = 1'b1;
                    tmr_val = TW'(CONV_CYC - 1);
                end
            end
            S_CONV: begin
                if (tmr_zero) begin
                    state_d = S_SCK_LO;
                    tmr_ld  = 1'b1;
                    tmr_val = TW'(HALF_CYC - 1);
                end
            end
            S_SCK_LO: begin
                if (tmr_zero) begin
                    smp     = 1'b1;
                    state_d = S_SCK_HI;
                    tmr_ld  = 1'b1;
                    tmr_val = TW'(HALF_CYC - 1);
                end
            end
            S_SCK_HI: begin
                if (tmr_zero) begin
                    if (full) begin
                        cap     = 1'b1;
                        state_d = S_DONE;
                    end else begin
                        state_d = S_SCK_LO;
                        tmr_ld  = 1'b1;
                        tmr_val = TW'(HALF_CYC - 1);
                    end
                end
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        start_o = (state_q == S_SEL_HI) || (state_q == S_TRACK);
        sclk_o  = (state_q == S_SCK_HI);
        done_o  = (state_q == S_DONE);
        busy_o  = (state_q != S_IDLE);
    end

    adc_seq_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_i     (tmr_ld),
        .ld_val_i (tmr_val),
        .zero_o   (tmr_zero)
    );

    adc_seq_shift #(.NBITS(NBITS)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .smp_i  (smp),
        .bit_i  (sdata_i),
        .data_o (shift_data),
        .full_o (full)
    );

    adc_seq_fmt #(.NBITS(NBITS), .EXT_W(EXT_W)) u_fmt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_i    (cap),
        .alt_i    (sel_q),
        .data_i   (shift_data),
        .result_o (result_o),
        .ext_o    (ext_o),
        .alt_o    (alt_o)
    );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int NBITS = 12,
    parameter int EXT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_o,
    input logic             sclk_o,
    input logic             done_o,
    input logic             busy_o,
    input logic             alt_o,
    input logic [NBITS-1:0] result_o,
    input logic [EXT_W-1:0] ext_o
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);  // R7

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(alt_o) && $stable(ext_o)));  // R7

    AST_IDLE_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!start_o && !sclk_o));  // R10

    AST_SCLK_START_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !start_o);  // R5

    AST_EXT_ZERO_PRIMARY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !alt_o) |-> (ext_o[EXT_W-1:NBITS] == '0));  // R8

    AST_EXT_LOW_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ext_o[NBITS-1:0] == result_o));  // R8

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);  // R9

endmodule

bind adc_seq_ctrl adc_seq_chk #(.NBITS(NBITS), .EXT_W(EXT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_o  (start_o),
    .sclk_o   (sclk_o),
    .done_o   (done_o),
    .busy_o   (busy_o),
    .alt_o    (alt_o),
    .result_o (result_o),
    .ext_o    (ext_o)
);

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;

    localparam int B_SEL  = 2;
    localparam int B_ACQ  = 5;
    localparam int B_CONV = 7;
    localparam int B_HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        sel_alt_i = 1'b0;
    logic        sdata_i = 1'b0;
    logic        start_o, sclk_o, alt_o, done_o, busy_o;
    logic [11:0] result_o;
    logic [15:0] ext_o;

    int checks = 0;
    int errors = 0;

    adc_seq_ctrl #(
        .NBITS(12), .EXT_W(16),
        .SEL_CYC(B_SEL), .ACQ_CYC(B_ACQ), .CONV_CYC(B_CONV), .HALF_CYC(B_HALF)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .sel_alt_i(sel_alt_i),
        .sdata_i(sdata_i), .start_o(start_o), .sclk_o(sclk_o),
        .result_o(result_o), .ext_o(ext_o), .alt_o(alt_o),
        .done_o(done_o), .busy_o(busy_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_ext(input bit alt, input logic [11:0] w);
        return alt ? {{4{w[11]}}, w} : {4'h0, w};
    endfunction

    // converter model
    logic [11:0] w_pri = '0, w_alt = '0, word = '0;
    logic st_p = 0, sk_p = 0;
    int   st_run = 0, sk_run = 0, pre_n = 0, gap = 0, rises = 0, falls = 0;
    bit   conv_on = 0, rd_done = 1, m_alt = 0, forced = 0;
    int   done_cnt = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) done_cnt++;
            if (conv_on) gap++;
            if (start_o != st_p) begin
                if (!start_o) begin
                    if (st_run < B_ACQ) begin
                        chk(st_run == B_SEL, "R3 select high width", st_run, B_SEL);
                        pre_n++;
                    end else begin
                        chk(st_run == B_ACQ, "R2 track width", st_run, B_ACQ);
                        forced  = !rd_done;
                        m_alt   = (pre_n > 0) || forced;
                        pre_n   = 0;
                        gap     = 0;
                        conv_on = 1;
                        rises   = 0;
                        falls   = 0;
                        rd_done = 0;
                        word    = m_alt ? w_alt : w_pri;
                        sdata_i = word[11];
                    end
                end else if (pre_n > 0) begin
                    chk(st_run == B_SEL, "R3 select low width", st_run, B_SEL);
                end
                st_run = 1;
            end else begin
                st_run++;
            end
            if (sclk_o != sk_p) begin
                if (sclk_o) begin
                    if (rises == 0) chk(gap >= B_CONV, "R4 conversion wait", gap, B_CONV);
                    else chk(sk_run == B_HALF, "R5 sclk low width", sk_run, B_HALF);
                    chk(!start_o, "R5 start low during sclk", start_o, 0);
                    rises++;
                end else begin
                    chk(sk_run == B_HALF, "R5 sclk high width", sk_run, B_HALF);
                    falls++;
                    if (falls == 12) begin
                        rd_done = 1;
                        conv_on = 0;
                    end
                    sdata_i = (falls < 12) ? word[11 - falls] : 1'b0;
                end
                sk_run = 1;
            end else begin
                sk_run++;
            end
            st_p = start_o;
            sk_p = sclk_o;
        end
    end

    task automatic do_conv(input bit sel, input logic [11:0] wp, input logic [11:0] wa, input bit poke);
        logic [11:0] ew;
        int dn0, n;
        w_pri = wp;
        w_alt = wa;
        ew  = sel ? wa : wp;
        dn0 = done_cnt;
        @(negedge clk);
        req_i = 1'b1;
        sel_alt_i = sel;
        @(negedge clk);
        req_i = 1'b0;
        chk(busy_o == 1'b1, "R10 busy after request", busy_o, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            req_i = 1'b1;
            sel_alt_i = !sel;
            @(negedge clk);
            req_i = 1'b0;
        end
        n = 0;
        while (!done_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done_o == 1'b1, "R7 done reached", done_o, 1);
        chk(result_o == ew, "R6 result", result_o, ew);
        chk(alt_o == sel, "R7 alt flag", alt_o, sel);
        chk(ext_o == exp_ext(sel, ew), "R8 extended", ext_o, exp_ext(sel, ew));
        chk(m_alt == sel, sel ? "R3 decoded choice" : "R2 decoded choice", m_alt, sel);
        chk(!forced, "R5 prior readout complete", forced, 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R7 done one cycle", done_o, 0);
        chk(falls == 12 && rises == 12, "R5 twelve sclk periods", falls, 12);
        chk(busy_o == 1'b0, "R10 busy drops", busy_o, 0);
        repeat (4) @(negedge clk);
        chk(result_o == ew && alt_o == sel, "R7 result held", result_o, ew);
        if (poke) begin
            chk(done_cnt == dn0 + 1, "R9 single conversion", done_cnt, dn0 + 1);
            chk(busy_o == 1'b0, "R9 no restart", busy_o, 0);
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h1d5);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!start_o && !sclk_o && !done_o && !busy_o && !alt_o, "R1 reset pins",
            {start_o, sclk_o, done_o, busy_o, alt_o}, 0);
        chk(result_o == 12'h0 && ext_o == 16'h0, "R1 reset data", result_o, 0);

        do_conv(1'b0, 12'hFFF, 12'h123, 1'b0);
        do_conv(1'b1, 12'h456, 12'h800, 1'b0);
        do_conv(1'b1, 12'h000, 12'h7FF, 1'b0);
        do_conv(1'b0, 12'h000, 12'hFFF, 1'b0);
        do_conv(1'b1, 12'h001, 12'hFFF, 1'b0);
        do_conv(1'b0, 12'hA5C, 12'h3C3, 1'b1);
        do_conv(1'b1, 12'h5A5, 12'h9E1, 1'b1);
        for (int i = 0; i < 30; i++) begin
            do_conv(1'($urandom), 12'($urandom), 12'($urandom), (i % 7) == 3);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule